// File: doc/BRIEF.md
# Two-Processor Shared Bus Arbiter Node

This block holds one copy of the mastership logic for an external bus shared by two processors and one host. Each processor carries its own copy. There is no central arbiter. A copy drives its own request line and watches the other processor's line. From the two lines, the host request and its own identity, each copy updates the same state machine. The two copies therefore agree every cycle on who owns the bus.

A processor raises its line for the whole of an access. It lowers the line to end the access. A lock input keeps the line raised between the read and the write of a read-modify-write, so the pair cannot be split. Every handover between owners passes through exactly one idle turnaround cycle. When both processors contend at a handover, the one that did not own the bus last wins. From a cold idle bus, the processor with identity 0 wins. The host outranks both processors whenever the bus is free. The host keeps the bus until it drops its request.

States:
- `ST_IDLE`: no owner and no handover pending.
- `ST_P0` and `ST_P1`: processor 0 or processor 1 owns the bus.
- `ST_TURN`: the one-cycle handover gap.
- `ST_HOST`: the host owns the bus.

Transitions:
- IDLE or TURN to HOST when the host requests.
- IDLE or TURN to P0 or P1 when there is no host request and a processor requests (tie rule as above). Otherwise TURN falls back to IDLE.
- P0 or P1 to TURN when the owner's line falls.
- HOST to TURN when the host request falls.

Top module: `bus_arb_node`

## Requirements
- R1: While `rst_n` is low, the node holds state IDLE with no previous owner, and `bus_mst` and `host_ack` are both 0.
- R2: `own_breq` is combinationally `loc_req | loc_lock`.
- R3: When the bus is idle or in turnaround, a processor whose line is sampled high at an edge, with no host request and no competing line, has `bus_mst` high from that edge on. A node whose line is low is never granted.
- R4: When both lines are sampled high in IDLE, or in a turnaround that follows host ownership, processor ID 0 is granted.
- R5: The owning processor keeps `bus_mst` high for as long as its line stays high, whatever the peer line and `host_req` do.
- R6: When the owner's line is sampled low, the next cycle is a turnaround cycle in which no processor and not the host owns the bus. Arbitration resumes at the edge after that.
- R7: When both lines are high in a turnaround that follows processor ownership, the processor that was not the previous owner is granted.
- R8: A `host_req` sampled high in IDLE or turnaround wins over both processors. `host_ack` goes high at that edge.
- R9: `host_ack` stays high while `host_req` stays high. After `host_req` falls, one turnaround cycle with no owner follows.
- R10: While the owner holds `loc_lock` high, it keeps `bus_mst` even with `loc_req` low and with peer and host requests pending.
- R11: The two nodes never both report `bus_mst`. `bus_mst` and `host_ack` are never high together. Both nodes report the same `host_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock shared by both nodes |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | 1 | Identity of this processor (0 or 1) |
| loc_req | input | 1 | Local processor wants the bus for the current access |
| loc_lock | input | 1 | Local processor holds the bus across a read-modify-write |
| peer_breq | input | 1 | Request line driven by the other processor's node |
| host_req | input | 1 | Host asks for the bus |
| own_breq | output | 1 | This processor's request line toward the peer |
| host_ack | output | 1 | Host owns the bus |
| bus_mst | output | 1 | This processor owns the bus |

## Verification
The key collision is a handover turnaround in which a host request and both processor lines arrive in the same cycle. The host must win, and the fairness rule must then be set aside in favour of the ID rule. A second collision is a locked owner with its access request low while the peer and the host both ask for the bus. Directed sequences provoke both collisions. Random stimulus from a fixed seed also produces them many times, with request, lock and host bits biased toward contention. Two nodes with IDs 0 and 1 are connected to each other. Every cycle, their grant and acknowledge outputs are compared with a bench model of the ownership rules.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    localparam int NPROC = 2;
    localparam int IDW   = $clog2(NPROC);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P0,
        ST_P1,
        ST_TURN,
        ST_HOST
    } arb_state_e;
endpackage

// File: rtl/bus_arb_lines.sv
module bus_arb_lines
    import bus_arb_pkg::*;
(
    input  logic [IDW-1:0]   my_id,
    input  logic             own_line,
    input  logic             peer_line,
    output logic [NPROC-1:0] req_by_id
);
    // Place the local and peer lines by absolute identity so both copies see the same vector.
    for (genvar g = 0; g < NPROC; g++) begin : g_map
        assign req_by_id[g] = (my_id == IDW'(g)) ? own_line : peer_line;
    end
endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
    import bus_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] req_by_id,
    input  logic             host_req,
    output arb_state_e       state
);
    arb_state_e     state_nx;
    logic           prev_v, prev_v_nx;
    logic [IDW-1:0] prev_id, prev_id_nx;
    logic           both;

    assign both = &req_by_id;

    always_comb begin
        state_nx   = state;
        prev_v_nx  = prev_v;
        prev_id_nx = prev_id;
        unique case (state)
            ST_IDLE, ST_TURN: begin
                if (host_req) begin
                    state_nx = ST_HOST;
                end else if (both) begin
                    // Fairness at a handover; otherwise the lower ID wins.
                    if (state == ST_TURN && prev_v)
                        state_nx = (prev_id == '0) ? ST_P1 : ST_P0;
                    else
                        state_nx = ST_P0;
                end else if (req_by_id[0]) begin
                    state_nx = ST_P0;
                end else if (req_by_id[1]) begin
                    state_nx = ST_P1;
                end else begin
                    state_nx  = ST_IDLE;
                    prev_v_nx = 1'b0;
                end
            end
            ST_P0: begin
                if (!req_by_id[0]) begin
                    state_nx   = ST_TURN;
                    prev_v_nx  = 1'b1;
                    prev_id_nx = IDW'(0);
                end
            end
            ST_P1: begin
                if (!req_by_id[1]) begin
                    state_nx   = ST_TURN;
                    prev_v_nx  = 1'b1;
                    prev_id_nx = IDW'(1);
                end
            end
            ST_HOST: begin
                if (!host_req) begin
                    state_nx  = ST_TURN;
                    prev_v_nx = 1'b0;
                end
            end
            default: begin
                state_nx  = ST_IDLE;
                prev_v_nx = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            prev_v  <= 1'b0;
            prev_id <= '0;
        end else begin
            state   <= state_nx;
            prev_v  <= prev_v_nx;
            prev_id <= prev_id_nx;
        end
    end
endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic my_id,
    input  logic loc_req,
    input  logic loc_lock,
    input  logic peer_breq,
    input  logic host_req,
    output logic own_breq,
    output logic host_ack,
    output logic bus_mst
);
    logic [NPROC-1:0] req_by_id;
    arb_state_e       state;

    // A lock keeps the line up between the read and the write.
    assign own_breq = loc_req | loc_lock;

    bus_arb_lines u_lines (
        .my_id     (my_id),
        .own_line  (own_breq),
        .peer_line (peer_breq),
        .req_by_id (req_by_id)
    );

    bus_arb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_by_id (req_by_id),
        .host_req  (host_req),
        .state     (state)
    );

    always_comb begin
        bus_mst  = 1'b0;
        host_ack = 1'b0;
        unique case (state)
            ST_P0:   bus_mst  = (my_id == 1'b0);
            ST_P1:   bus_mst  = (my_id == 1'b1);
            ST_HOST: host_ack = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_arb_node_chk.sv
module bus_arb_node_chk (
    input logic clk,
    input logic rst_n,
    input logic loc_lock,
    input logic host_req,
    input logic own_breq,
    input logic host_ack,
    input logic bus_mst
);
    AST_MST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_mst && host_ack)); // R11
    AST_NO_GRANT_UNREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mst && !own_breq) |=> !bus_mst); // R3
    AST_MASTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mst && own_breq) |=> bus_mst); // R5
    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mst && !own_breq) |=> (!bus_mst && !host_ack)); // R6
    AST_HOST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && host_req) |=> host_ack); // R9
    AST_HOST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !host_req) |=> (!host_ack && !bus_mst)); // R9
    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mst && loc_lock) |=> bus_mst); // R10
endmodule

bind bus_arb_node bus_arb_node_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .loc_lock (loc_lock),
    .host_req (host_req),
    .own_breq (own_breq),
    .host_ack (host_ack),
    .bus_mst  (bus_mst)
);

// File: tb/test_bus_arb_node.sv
module test_bus_arb_node;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req0 = 0, lock0 = 0, req1 = 0, lock1 = 0, hreq = 0;
    logic breq0, breq1, mst0, mst1, ack0, ack1;

    int n_run = 0;
    int n_fail = 0;
    string phase = "R1";

    // model: 0 idle, 1 P0, 2 P1, 3 turn, 4 host; prev -1 = none
    int m_st = 0;
    int m_prev = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_arb_node i_bus_arb_node (
        .clk(clk), .rst_n(rst_n), .my_id(1'b0), .loc_req(req0), .loc_lock(lock0),
        .peer_breq(breq1), .host_req(hreq), .own_breq(breq0), .host_ack(ack0), .bus_mst(mst0)
    );

    bus_arb_node i_bus_arb_node_b (
        .clk(clk), .rst_n(rst_n), .my_id(1'b1), .loc_req(req1), .loc_lock(lock1),
        .peer_breq(breq0), .host_req(hreq), .own_breq(breq1), .host_ack(ack1), .bus_mst(mst1)
    );

    function automatic int model_next(int st, int prev, bit r0, bit r1, bit h);
        if (st == 0 || st == 3) begin
            if (h) return 4;
            if (r0 && r1) begin
                if (st == 3 && prev >= 0) return (prev == 0) ? 2 : 1;
                return 1;
            end
            if (r0) return 1;
            if (r1) return 2;
            return 0;
        end
        if (st == 1) return r0 ? 1 : 3;
        if (st == 2) return r1 ? 2 : 3;
        return h ? 4 : 3;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        bit r0, r1;
        int nx;
        @(posedge clk);
        r0 = req0 | lock0;
        r1 = req1 | lock1;
        nx = model_next(m_st, m_prev, r0, r1, hreq);
        if (m_st == 1 && nx == 3) m_prev = 0;
        else if (m_st == 2 && nx == 3) m_prev = 1;
        else if (m_st == 4 && nx == 3) m_prev = -1;
        else if (nx == 0) m_prev = -1;
        m_st = nx;
        @(negedge clk);
        chk({phase, " mst0"}, mst0, m_st == 1);
        chk({phase, " mst1"}, mst1, m_st == 2);
        chk({phase, " ack0"}, ack0, m_st == 4);
        chk({phase, " ack1"}, ack1, m_st == 4);
        chk("R11 excl", !(mst0 && mst1) && !((mst0 || mst1) && ack0), 1'b1);
        chk("R2 line0", breq0, req0 | lock0);
        chk("R2 line1", breq1, req1 | lock1);
    endtask

    task automatic drive(bit a, bit la, bit b, bit lb, bit h);
        req0 = a; lock0 = la; req1 = b; lock1 = lb; hreq = h;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        drive(1, 0, 1, 0, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 mst0 in reset", mst0, 1'b0);
        chk("R1 mst1 in reset", mst1, 1'b0);
        chk("R1 ack in reset", ack0 | ack1, 1'b0);
        drive(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        step();

        phase = "R3"; drive(0, 0, 1, 0, 0); step(); step();
        chk("R3 proc1 granted", mst1, 1'b1);
        phase = "R6"; drive(0, 0, 0, 0, 0); step();
        chk("R6 gap no owner", mst0 | mst1 | ack0, 1'b0);
        step();
        phase = "R4"; drive(1, 0, 1, 0, 0); step();
        chk("R4 ID0 wins from idle", mst0, 1'b1);
        phase = "R5"; drive(1, 0, 1, 0, 1); step(); step();
        chk("R5 owner keeps", mst0, 1'b1);
        phase = "R7"; drive(0, 0, 1, 0, 0); step();
        chk("R6 turnaround", mst0 | mst1, 1'b0);
        drive(1, 0, 1, 0, 0); step();
        chk("R7 non-previous wins", mst1, 1'b1);
        phase = "R8"; drive(1, 0, 0, 0, 1); step(); step();
        chk("R8 host beats both", ack0 & ack1, 1'b1);
        phase = "R9"; drive(1, 0, 1, 0, 1); step(); step();
        chk("R9 host keeps", ack0, 1'b1);
        drive(1, 0, 1, 0, 0); step();
        chk("R9 gap after host", mst0 | mst1 | ack0, 1'b0);
        step();
        chk("R4 ID0 wins after host", mst0, 1'b1);
        phase = "R10"; drive(0, 1, 1, 0, 1); step(); step(); step();
        chk("R10 lock keeps", mst0, 1'b1);
        drive(0, 0, 1, 0, 1); step(); step();
        chk("R8 host after lock", ack0, 1'b1);
        drive(0, 0, 0, 0, 0); step(); step();

        phase = "R11 random";
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 4) != 0, ($urandom % 8) == 0,
                  ($urandom % 4) != 0, ($urandom % 8) == 0,
                  ($urandom % 6) == 0);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule